// File: doc/BRIEF.md
# Codec Serial Port with Delayed Frame Sync

This block is the digital serial port of a codec-style converter. In each frame it moves one 16-bit word out on a serial data line and one 16-bit word in on another, at the same time, inside an active-low frame-sync window. The parallel side supplies the word to send and receives each completed incoming word together with a one-cycle valid strobe.

The port has two modes. As master it divides the master clock by four to make the shift clock, and issues a frame sync every 256 shift clocks. As slave it takes the shift clock and the frame sync from outside; both are synchronous to the master clock.

The port also drives a second active-low frame sync for chaining another device. This pulse is as wide as the master frame sync and starts a programmable number of shift clocks later. A power-down input freezes all activity and keeps the programmed state.

Top module: `codec_serial_port`

## Requirements
- R1: With `masterSel` high, `sclkOut` toggles with a period of 4 master clocks: high for 2 and low for 2. With `masterSel` low, `sclkOut` stays 0, `fsOut` stays 1 and shifting is timed by `sclkIn`.
- R2: In master mode `fsOut` is active low. It falls on the first rising shift clock after reset and then once every 256 rising shift clocks. It stays low for exactly 16 rising shift clocks.
- R3: `txWord` is captured at the rising shift clock that starts a frame. Later changes have no effect on that frame. `sdOut` carries the captured word MSB first, with a new bit after each rising shift clock: bit 15 after the starting edge, bit 0 after the 16th.
- R4: `sdIn` is sampled on falling shift-clock edges, MSB first, starting with the first falling edge after the frame start. After the 16th sample, `rxWord` holds the word and `rxValid` is high for exactly one master-clock cycle. `rxValid` is low at every other time.
- R5: In slave mode a frame starts at a rising `sclkIn` edge where `fsIn` is sampled low after being sampled high at the previous rising edge. Holding `fsIn` low for one shift clock is enough. Exactly 16 bits move in each direction whatever the width of `fsIn`, and a longer low time does not start a second frame.
- R6: `fsDlyN` is active low and stays low for 16 rising shift clocks. It falls D rising shift clocks after the frame start, where D is the delay value captured at that start. With D = 0 it matches `fsOut` cycle for cycle.
- R7: The 8-bit delay value is written by holding `dlyWe` high for one master clock with the value on `dlyWd`. It applies from the next frame start. Its reset value is 0.
- R8: While `rstN` is low, `sclkOut`, `sdOut` and `rxValid` are 0 and `fsOut` and `fsDlyN` are 1. Reset also clears every counter and the delay value.
- R9: While `pdN` is low, shift-clock generation, frame timing and both shift registers hold their state, and delay writes are ignored. When `pdN` returns high, a frame in progress completes with its data intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pdN | input | 1 | Power-down, active low; freezes the port |
| masterSel | input | 1 | 1 = master, 0 = slave |
| sclkIn | input | 1 | External shift clock (slave) |
| sclkOut | output | 1 | Generated shift clock (master) |
| fsIn | input | 1 | External frame sync, active low (slave) |
| fsOut | output | 1 | Generated frame sync, active low (master) |
| fsDlyN | output | 1 | Delayed frame sync, active low |
| sdIn | input | 1 | Serial receive data |
| sdOut | output | 1 | Serial transmit data |
| txWord | input | 16 | Word to send in the next frame |
| rxWord | output | 16 | Last word received |
| rxValid | output | 1 | One-cycle strobe when `rxWord` updates |
| dlyWe | input | 1 | Delay value write enable |
| dlyWd | input | 8 | Delay value, in shift clocks |

## Verification
The assertions assume that `masterSel` changes only while reset is held. They also assume that in slave mode `sclkIn` stays at each level for at least one master clock, so that a rise and a fall never appear in the same cycle. The cycle-for-cycle check of the delayed sync with a zero delay applies to master mode only. The stimulus switches mode only inside reset and holds each slave shift-clock level for two master clocks. It moves `fsIn` and `sdIn` only together with a rising `sclkIn`, and uses master delays small enough that each delayed pulse ends before the next frame.

// File: rtl/csp_pkg.sv
package csp_pkg;
  // strobes from control to datapath, at most one shift strobe per cycle
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic shiftRx;
    logic rxDone;
  } ctlStb_t;
endpackage

// File: rtl/csp_clkgen.sv
module csp_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pdN,
  input  logic masterSel,
  input  logic sclkIn,
  output logic sclkOut,
  output logic riseStb,
  output logic fallStb
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] divCnt;
  logic sclkInQ;
  logic mRise, mFall, sRise, sFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (pdN && masterSel) begin
      if (divCnt == CNT_W'(CLK_DIV - 1)) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkInQ <= 1'b0;
    else sclkInQ <= sclkIn;
  end

  assign mRise = (divCnt == CNT_W'(HALF - 1));
  assign mFall = (divCnt == CNT_W'(CLK_DIV - 1));
  assign sRise = sclkIn & ~sclkInQ;
  assign sFall = ~sclkIn & sclkInQ;

  assign riseStb = pdN & (masterSel ? mRise : sRise);
  assign fallStb = pdN & (masterSel ? mFall : sFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkOut <= 1'b0;
    else if (!masterSel) sclkOut <= 1'b0;
    else if (riseStb) sclkOut <= 1'b1;
    else if (fallStb) sclkOut <= 1'b0;
  end

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb));
  assert_sclk_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    (riseStb && masterSel) |=> sclkOut);
  assert_pd_sclk_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pdN |=> $stable(sclkOut));
endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int FRAME_LEN = 256,
  parameter int DLY_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pdN,
  input  logic             masterSel,
  input  logic             riseStb,
  input  logic             fallStb,
  input  logic             fsIn,
  input  logic             dlyWe,
  input  logic [DLY_W-1:0] dlyWd,
  output logic             fsOut,
  output logic             fsDlyN,
  output ctlStb_t          stb
);
  localparam int FRM_W = $clog2(FRAME_LEN);
  localparam int BIT_W = $clog2(WORD_W);

  logic [FRM_W-1:0] frameCnt;
  logic [BIT_W-1:0] rxCnt;
  logic [BIT_W-1:0] widthCnt;
  logic [DLY_W-1:0] dlyReg;
  logic [DLY_W-1:0] curDly;
  logic [DLY_W-1:0] pendCnt;
  logic             dlyPend;
  logic             fsAtRise;
  logic             active;
  logic             startFrame;

  assign startFrame = riseStb &
    (masterSel ? (frameCnt == '0) : (!fsIn && fsAtRise));

  always_comb begin
    stb         = '0;
    stb.loadTx  = startFrame;
    stb.shiftTx = riseStb & active & ~startFrame;
    stb.shiftRx = fallStb & active;
    stb.rxDone  = fallStb & active & (rxCnt == BIT_W'(WORD_W - 1));
  end

  // frame timing and master frame sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      fsOut    <= 1'b1;
      fsAtRise <= 1'b1;
    end else if (riseStb) begin
      fsAtRise <= fsIn;
      if (masterSel) begin
        fsOut <= !(frameCnt < FRM_W'(WORD_W));
        if (frameCnt == FRM_W'(FRAME_LEN - 1)) frameCnt <= '0;
        else frameCnt <= frameCnt + 1'b1;
      end else begin
        fsOut <= 1'b1;
      end
    end
  end

  // bit counting for one transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      rxCnt  <= '0;
    end else if (startFrame) begin
      active <= 1'b1;
      rxCnt  <= '0;
    end else if (stb.shiftRx) begin
      rxCnt <= rxCnt + 1'b1;
      if (stb.rxDone) active <= 1'b0;
    end
  end

  // delay value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyReg <= '0;
    else if (dlyWe && pdN) dlyReg <= dlyWd;
  end

  // delayed frame sync
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsDlyN   <= 1'b1;
      widthCnt <= '0;
      pendCnt  <= '0;
      dlyPend  <= 1'b0;
      curDly   <= '0;
    end else if (riseStb) begin
      if (!fsDlyN) begin
        if (widthCnt == '0) fsDlyN <= 1'b1;
        else widthCnt <= widthCnt - 1'b1;
      end
      if (startFrame) begin
        curDly <= dlyReg;
        if (dlyReg == '0) begin
          fsDlyN   <= 1'b0;
          widthCnt <= BIT_W'(WORD_W - 1);
          dlyPend  <= 1'b0;
        end else begin
          dlyPend <= 1'b1;
          pendCnt <= dlyReg;
        end
      end else if (dlyPend) begin
        if (pendCnt == DLY_W'(1)) begin
          fsDlyN   <= 1'b0;
          widthCnt <= BIT_W'(WORD_W - 1);
          dlyPend  <= 1'b0;
        end else begin
          pendCnt <= pendCnt - 1'b1;
        end
      end
    end
  end

  assert_dly_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (masterSel && curDly == '0) |-> (fsDlyN == fsOut));
endmodule

// File: rtl/csp_datapath.sv
module csp_datapath
  import csp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              sdIn,
  output logic              sdOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  assign rxNext = {rxShift[WORD_W-2:0], sdIn};
  assign sdOut  = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (stb.loadTx) txShift <= txWord;
    else if (stb.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.rxDone;
      if (stb.shiftRx) rxShift <= rxNext;
      if (stb.rxDone) rxWord <= rxNext;
    end
  end

  assert_rxvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int FRAME_LEN = 256,
  parameter int DLY_W     = 8,
  parameter int CLK_DIV   = 4
) (
  input  logic              mclk,
  input  logic              rstN,
  input  logic              pdN,
  input  logic              masterSel,
  input  logic              sclkIn,
  output logic              sclkOut,
  input  logic              fsIn,
  output logic              fsOut,
  output logic              fsDlyN,
  input  logic              sdIn,
  output logic              sdOut,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  input  logic              dlyWe,
  input  logic [DLY_W-1:0]  dlyWd
);
  logic    riseStb;
  logic    fallStb;
  ctlStb_t stb;

  csp_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk(mclk), .rstN(rstN), .pdN(pdN), .masterSel(masterSel),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .riseStb(riseStb), .fallStb(fallStb)
  );

  csp_ctrl #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN), .DLY_W(DLY_W)) u_ctrl (
    .clk(mclk), .rstN(rstN), .pdN(pdN), .masterSel(masterSel),
    .riseStb(riseStb), .fallStb(fallStb), .fsIn(fsIn),
    .dlyWe(dlyWe), .dlyWd(dlyWd),
    .fsOut(fsOut), .fsDlyN(fsDlyN), .stb(stb)
  );

  csp_datapath #(.WORD_W(WORD_W)) u_datapath (
    .clk(mclk), .rstN(rstN), .stb(stb), .txWord(txWord), .sdIn(sdIn),
    .sdOut(sdOut), .rxWord(rxWord), .rxValid(rxValid)
  );

  assert_pd_hold_R9: assert property (@(posedge mclk) disable iff (!rstN)
    !pdN |=> ($stable(rxWord) && $stable(sdOut) && $stable(fsOut) && $stable(fsDlyN)));
endmodule

// File: tb/codec_serial_port_tb.sv
module codec_serial_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pdN = 1'b1;
  logic        masterSel = 1'b1;
  logic        sclkIn = 1'b0;
  logic        fsIn = 1'b1;
  logic        sdIn = 1'b0;
  logic [15:0] txWord = '0;
  logic        dlyWe = 1'b0;
  logic [7:0]  dlyWd = '0;
  logic        sclkOut, fsOut, fsDlyN, sdOut, rxValid;
  logic [15:0] rxWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  codec_serial_port u_dut (
    .mclk(clk), .rstN(rstN), .pdN(pdN), .masterSel(masterSel),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .fsIn(fsIn), .fsOut(fsOut),
    .fsDlyN(fsDlyN), .sdIn(sdIn), .sdOut(sdOut), .txWord(txWord),
    .rxWord(rxWord), .rxValid(rxValid), .dlyWe(dlyWe), .dlyWd(dlyWd)
  );

  // bench tracking state for master mode
  logic        sPrev, fsPrev, dlyPrev, pdPrev;
  int          cyc, riseCnt, startRise, lastRiseCyc, dlyFall, fallIdx, bitIdx;
  int          curD, frameD;
  bit          active;
  logic [15:0] expTx, expRx, gotTx;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reset_dut(input logic mode);
    @(negedge clk);
    rstN = 1'b0; masterSel = mode; pdN = 1'b1; sclkIn = 1'b0; fsIn = 1'b1;
    dlyWe = 1'b0;
    repeat (3) begin
      @(negedge clk);
      // R8: idle outputs during reset
      chk(sclkOut == 1'b0 && sdOut == 1'b0 && rxValid == 1'b0, "R8", "reset low outputs",
          int'({sclkOut, sdOut, rxValid}), 0);
      chk(fsOut == 1'b1 && fsDlyN == 1'b1, "R8", "reset sync outputs",
          int'({fsOut, fsDlyN}), 3);
    end
    rstN = 1'b1;
    sPrev = 0; fsPrev = 1; dlyPrev = 1; pdPrev = 1;
    cyc = 0; riseCnt = 0; startRise = -1; lastRiseCyc = -1; dlyFall = 0;
    fallIdx = 0; bitIdx = 0; active = 0; curD = 0; frameD = 0;
  endtask

  task automatic master_frames(input int n, input int newD, input bit doPd);
    int done = 0;
    int it = 0;
    int pdCnt = -1;
    logic sNow, fsNow, dlyNow, rose, fellS, expV;
    while (done < n) begin
      @(negedge clk);
      cyc++;
      sNow = sclkOut; fsNow = fsOut; dlyNow = fsDlyN;
      rose = sNow & ~sPrev;
      fellS = ~sNow & sPrev;
      if (!pdPrev) begin
        chk(sNow == sPrev, "R9", "sclk frozen in power-down", int'(sNow), int'(sPrev));
        chk(fsNow == fsPrev && dlyNow == dlyPrev, "R9", "syncs frozen",
            int'({fsNow, dlyNow}), int'({fsPrev, dlyPrev}));
      end
      if (rose) begin
        riseCnt++;
        if (lastRiseCyc >= 0) chk(cyc - lastRiseCyc == 4, "R1", "sclk period", cyc - lastRiseCyc, 4);
        lastRiseCyc = cyc;
        if (!fsNow && fsPrev) begin
          if (startRise >= 0) chk(riseCnt - startRise == 256, "R2", "frame period", riseCnt - startRise, 256);
          else chk(riseCnt == 1, "R2", "first frame start", riseCnt, 1);
          startRise = riseCnt;
          expTx = txWord;
          txWord = 16'($urandom);
          expRx = 16'($urandom);
          bitIdx = 0; fallIdx = 0; active = 1; frameD = curD; gotTx = '0;
        end
        if (fsNow && !fsPrev) chk(riseCnt - startRise == 16, "R2", "fs low width", riseCnt - startRise, 16);
        if (!dlyNow && dlyPrev) begin
          chk(riseCnt - startRise == frameD, "R6", "delayed sync offset", riseCnt - startRise, frameD);
          dlyFall = riseCnt;
        end
        if (dlyNow && !dlyPrev) chk(riseCnt - dlyFall == 16, "R6", "delayed sync width", riseCnt - dlyFall, 16);
        if (frameD == 0) chk(dlyNow == fsNow, "R6", "zero delay matches fs", int'(dlyNow), int'(fsNow));
        if (active && bitIdx < 16) begin
          gotTx = {gotTx[14:0], sdOut};
          sdIn = expRx[15 - bitIdx];
          bitIdx++;
        end
      end
      if (fellS) begin
        if (lastRiseCyc >= 0) chk(cyc - lastRiseCyc == 2, "R1", "sclk high time", cyc - lastRiseCyc, 2);
        if (active) fallIdx++;
      end
      expV = fellS && active && fallIdx == 16;
      if (rxValid !== expV) chk(0, "R4", "rxValid timing", int'(rxValid), int'(expV));
      if (expV) begin
        chk(rxWord == expRx, "R4", "received word", int'(rxWord), int'(expRx));
        chk(gotTx == expTx, "R3", "transmitted word", int'(gotTx), int'(expTx));
        active = 0;
        done++;
      end
      sPrev = sNow; fsPrev = fsNow; dlyPrev = dlyNow;
      // drive
      dlyWe = 1'b0;
      if (it == 0 && newD >= 0) begin
        dlyWe = 1'b1; dlyWd = 8'(newD); curD = newD;
      end
      if (doPd && done == 0 && active && bitIdx == 8 && pdCnt < 0) begin
        pdCnt = 0; pdN = 1'b0; lastRiseCyc = -1;
      end else if (pdCnt >= 0 && pdCnt < 40) begin
        pdCnt++;
        if (pdCnt == 5) begin dlyWe = 1'b1; dlyWd = 8'd77; end // R9: ignored
        if (pdCnt == 40) pdN = 1'b1;
      end
      pdPrev = pdN;
      it++;
    end
  endtask

  task automatic slave_chk(input logic expV);
    chk(sclkOut == 1'b0 && fsOut == 1'b1, "R1", "slave leaves sclkOut/fsOut idle",
        int'({sclkOut, fsOut}), 1);
    if (rxValid !== expV) chk(0, "R5", "slave rxValid timing", int'(rxValid), int'(expV));
  endtask

  task automatic slave_frame(input logic [15:0] tx, input logic [15:0] rx, input int fsLow);
    int total;
    logic [15:0] got;
    total = ((fsLow > 16) ? fsLow : 16) + 2;
    got = '0;
    txWord = tx;
    for (int p = 0; p < total; p++) begin
      @(negedge clk);
      slave_chk(1'b0);
      sclkIn = 1'b1;
      fsIn = (p < fsLow) ? 1'b0 : 1'b1;
      sdIn = (p < 16) ? rx[15 - p] : 1'b0;
      if (p == 1) txWord = ~tx; // R3: change after capture
      @(negedge clk);
      slave_chk(1'b0);
      if (p < 16) got = {got[14:0], sdOut};
      @(negedge clk);
      slave_chk(1'b0);
      sclkIn = 1'b0;
      @(negedge clk);
      slave_chk(p == 15);
      if (p == 15) chk(rxWord == rx, "R5", "slave received word", int'(rxWord), int'(rx));
    end
    chk(got == tx, "R5", "slave transmitted word", int'(got), int'(tx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    txWord = 16'($urandom);
    // master phase, default delay of zero (R7)
    reset_dut(1'b1);
    master_frames(2, -1, 1'b0);
    master_frames(2, 5, 1'b0);
    master_frames(2, 200, 1'b1);   // R9 power-down mid-frame, write ignored
    master_frames(1, 0, 1'b0);
    master_frames(1, 9, 1'b0);
    // reset clears the delay value (R7, R8)
    reset_dut(1'b1);
    master_frames(2, -1, 1'b0);
    // slave phase (R5)
    reset_dut(1'b0);
    repeat (2) begin
      @(negedge clk); sclkIn = 1'b1;
      @(negedge clk);
      @(negedge clk); sclkIn = 1'b0;
      @(negedge clk);
    end
    slave_frame(16'hA5C3, 16'h0F0F, 1);
    slave_frame(16'($urandom), 16'($urandom), 16);
    slave_frame(16'($urandom), 16'($urandom), 20);
    slave_frame(16'h8001, 16'hFFFF, 3);
    slave_frame(16'($urandom), 16'($urandom), 2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule